// File: doc/BRIEF.md
# Multi-Mode Timer/Counter

A 16-bit timer/counter held as a high byte and a low byte, each loadable through a byte write port. It advances on a one-per-machine-cycle enable, counting either every machine cycle (timer use) or each falling edge seen on an external pin (counter use). A two-bit mode input changes its width and reload behaviour at run time. It can run as a 13-bit counter with a 5-bit prescaler in the low byte, as a plain 16-bit counter, or as an 8-bit counter that reloads itself from the high byte.

Each overflow sets a sticky flag that serves as an interrupt request until it is cleared. It also produces a one-clock overflow pulse, which a serial port can use as its bit-rate tick. Counting needs the run input set. When gating is enabled, it also needs the external gate pin high, which lets software measure how long that pin stays high.

Top module: `tmr_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted and on the first cycle after it, both count bytes, the flag and the pulse read 0.
- R2: A write strobe loads `wr_data` into the selected byte, and the value shows on the next cycle. No count happens in a cycle that carries any write strobe.
- R3: A count happens only on a cycle with `cyc_en` high and `run` high, and only if `gate_en` is low or `gate_pin` is high.
- R4: With `mode` = 2'b01 the count is {hi,lo}+1. The step from 16'hFFFF to 16'h0000 is an overflow.
- R5: With `mode` = 2'b00, lo[4:0] is a 5-bit prescaler that carries into hi, and lo[7:5] never changes by counting. The step from hi=8'hFF, lo[4:0]=5'h1F wraps both parts to 0 and is an overflow.
- R6: With `mode` = 2'b10 only lo counts. The step from lo=8'hFF is an overflow, loads lo from hi in the same cycle, and leaves hi unchanged.
- R7: With `mode` = 2'b11 the counter does not count and no overflow occurs.
- R8: With `cnt_sel` = 1, `ext_pin` is sampled on every `cyc_en` cycle. A count takes place on the `cyc_en` cycle that follows a 1 sample and then a 0 sample.
- R9: `ovf_flag` sets on an overflow and stays set until a cycle with `flag_clr` high and no overflow. If an overflow and a clear fall in the same cycle, the flag stays set.
- R10: `ovf_pulse` is high for exactly the clock after each overflow step, and it rises at the same time as the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | One-per-machine-cycle enable |
| mode | input | 2 | 00 13-bit, 01 16-bit, 10 8-bit reload, 11 stopped |
| cnt_sel | input | 1 | 0 counts machine cycles, 1 counts pin edges |
| run | input | 1 | Run control |
| gate_en | input | 1 | Require gate_pin high to count |
| gate_pin | input | 1 | External gate level |
| ext_pin | input | 1 | External count input |
| wr_lo | input | 1 | Write strobe for the low byte |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Clear the overflow flag |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag (interrupt request) |
| ovf_pulse | output | 1 | One-clock overflow pulse (bit-rate tick) |

## Verification
The count bytes are outputs, so a wrong carry or wrong reload value appears on `cnt_lo`/`cnt_hi` on the clock after the faulty step. The bench compares both bytes on every cycle, so such a fault is caught there. A wrong edge-sampler state is not visible directly. It shows up as a count that is missing, early or extra, and appears one machine cycle after the pin pattern that should have caused it. A fault in the flag or pulse path appears as a flag or pulse that disagrees with the overflow step on that same clock.

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic [1:0]        mode,
  input  logic              cnt_sel,
  input  logic              run,
  input  logic              gate_en,
  input  logic              gate_pin,
  input  logic              ext_pin,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flag_clr,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_flag,
  output logic              ovf_pulse
);
  localparam int CNT_W = 2 * BYTE_W;

  logic              smp_now, smp_old;
  logic              allowed, src_hit, inc, wrap;
  logic [BYTE_W-1:0] nxt_lo, nxt_hi;
  logic [PRE_W:0]    pre_sum;
  logic [BYTE_W:0]   hi_sum;
  logic [CNT_W:0]    full_sum;

  assign allowed = cyc_en & run & (~gate_en | gate_pin);
  assign src_hit = cnt_sel ? (smp_old & ~smp_now) : 1'b1;
  assign inc     = allowed & src_hit & ~wr_lo & ~wr_hi & (mode != 2'b11);

  assign pre_sum  = {1'b0, cnt_lo[PRE_W-1:0]} + 1'b1;
  assign hi_sum   = {1'b0, cnt_hi} + pre_sum[PRE_W];
  assign full_sum = {1'b0, cnt_hi, cnt_lo} + 1'b1;

  always_comb begin
    nxt_lo = cnt_lo;
    nxt_hi = cnt_hi;
    wrap   = 1'b0;
    case (mode)
      2'b00: begin
        nxt_lo = {cnt_lo[BYTE_W-1:PRE_W], pre_sum[PRE_W-1:0]};
        nxt_hi = hi_sum[BYTE_W-1:0];
        wrap   = hi_sum[BYTE_W];
      end
      2'b01: begin
        {wrap, nxt_hi, nxt_lo} = full_sum;
      end
      2'b10: begin
        wrap   = &cnt_lo;
        nxt_lo = wrap ? cnt_hi : cnt_lo + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_now   <= 1'b0;
      smp_old   <= 1'b0;
      cnt_lo    <= '0;
      cnt_hi    <= '0;
      ovf_flag  <= 1'b0;
      ovf_pulse <= 1'b0;
    end else begin
      if (cyc_en) begin
        smp_now <= ext_pin;
        smp_old <= smp_now;
      end
      if (wr_lo)    cnt_lo <= wr_data;
      else if (inc) cnt_lo <= nxt_lo;
      if (wr_hi)    cnt_hi <= wr_data;
      else if (inc) cnt_hi <= nxt_hi;
      ovf_pulse <= inc & wrap;
      ovf_flag  <= (inc & wrap) | (ovf_flag & ~flag_clr);
    end
  end
endmodule

module tmr_unit_chk #(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              run,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic              flag_clr,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic              ovf_flag,
  input logic              ovf_pulse
);
  AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n) ovf_pulse |-> ovf_flag); // R10
  AST_FLAG_RISE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf_flag) |-> ovf_pulse); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf_flag && !flag_clr) |=> ovf_flag); // R9
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b10 && !wr_lo && !wr_hi) |=> (ovf_pulse |-> cnt_lo == cnt_hi)); // R6
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b11 && !wr_lo && !wr_hi) |=> ($stable({cnt_hi, cnt_lo}) && !ovf_pulse)); // R7
  AST_NO_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!run && !wr_lo && !wr_hi) |=> $stable({cnt_hi, cnt_lo})); // R3
  AST_PRESCALE_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b00 && !wr_lo) |=> $stable(cnt_lo[BYTE_W-1:PRE_W])); // R5
endmodule

bind tmr_unit tmr_unit_chk #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) i_tmr_unit_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .run(run), .wr_lo(wr_lo), .wr_hi(wr_hi),
  .flag_clr(flag_clr), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
);

// File: tb/test_tmr_unit.sv
`timescale 1ns/1ps
module test_tmr_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_en = 0, cnt_sel = 0, run = 0, gate_en = 0, gate_pin = 0, ext_pin = 0;
  logic wr_lo = 0, wr_hi = 0, flag_clr = 0;
  logic [1:0] mode = 2'b01;
  logic [7:0] wr_data = 0;
  logic [7:0] cnt_lo, cnt_hi;
  logic ovf_flag, ovf_pulse;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_lo = 0, m_hi = 0;
  bit m_flag = 0, m_pulse = 0, m_s0 = 0, m_s1 = 0;
  string m_tag = "R1";

  always #2 clk = ~clk;

  tmr_unit i_tmr_unit (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .mode(mode), .cnt_sel(cnt_sel), .run(run),
    .gate_en(gate_en), .gate_pin(gate_pin), .ext_pin(ext_pin), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .flag_clr(flag_clr), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'b00: return "R5";
      2'b01: return "R4";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic model_step();
    bit inc, ovf;
    logic [8:0] s9;
    logic [5:0] s6;
    logic [16:0] s17;
    ovf = 0;
    inc = cyc_en && run && (!gate_en || gate_pin) && (!cnt_sel || (m_s1 && !m_s0))
          && !wr_lo && !wr_hi && mode != 2'b11;
    m_tag = (wr_lo || wr_hi) ? "R2" : (!run || (gate_en && !gate_pin)) ? "R3" :
            cnt_sel ? "R8" : mode_tag(mode);
    if (wr_lo) m_lo = wr_data;
    if (wr_hi) m_hi = wr_data;
    if (inc) begin
      case (mode)
        2'b00: begin
          s6 = {1'b0, m_lo[4:0]} + 6'd1;
          s9 = {1'b0, m_hi} + {8'd0, s6[5]};
          m_lo = {m_lo[7:5], s6[4:0]};
          m_hi = s9[7:0];
          ovf = s9[8];
        end
        2'b01: begin
          s17 = {1'b0, m_hi, m_lo} + 17'd1;
          {ovf, m_hi, m_lo} = s17;
        end
        default: begin
          ovf = (m_lo == 8'hFF);
          m_lo = ovf ? m_hi : m_lo + 8'd1;
        end
      endcase
    end
    if (cyc_en) begin
      m_s1 = m_s0;
      m_s0 = ext_pin;
    end
    m_pulse = ovf;
    m_flag = ovf || (m_flag && !flag_clr);
  endtask

  task automatic compare();
    chk(cnt_lo == m_lo, m_tag, cnt_lo, m_lo);
    chk(cnt_hi == m_hi, m_tag, cnt_hi, m_hi);
    chk(ovf_flag == m_flag, "R9", ovf_flag, m_flag);
    chk(ovf_pulse == m_pulse, "R10", ovf_pulse, m_pulse);
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    wr_lo = 0; wr_hi = 0; flag_clr = 0;
  endtask

  task automatic load(input logic [7:0] hi, input logic [7:0] lo);
    wr_hi = 1; wr_lo = 0; wr_data = hi; tick();
    wr_hi = 0; wr_lo = 1; wr_data = lo; tick();
    quiet();
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cnt_lo == 0 && cnt_hi == 0 && !ovf_flag && !ovf_pulse, "R1", {cnt_hi, cnt_lo}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cnt_lo == 0 && cnt_hi == 0 && !ovf_flag, "R1", {cnt_hi, cnt_lo}, 0);

    // R2 write then read
    load(8'h12, 8'h34);
    chk({cnt_hi, cnt_lo} == 16'h1234, "R2", {cnt_hi, cnt_lo}, 16'h1234);

    // R4 16-bit wrap
    mode = 2'b01; cyc_en = 1; run = 1;
    load(8'hFF, 8'hFE);
    tick();
    chk({cnt_hi, cnt_lo} == 16'hFFFF, "R4", {cnt_hi, cnt_lo}, 16'hFFFF);
    tick();
    chk({cnt_hi, cnt_lo} == 16'h0000 && ovf_pulse && ovf_flag, "R4", {cnt_hi, cnt_lo}, 0);
    tick();
    chk(!ovf_pulse && ovf_flag, "R10", ovf_pulse, 0);
    flag_clr = 1; tick(); quiet();
    chk(!ovf_flag, "R9", ovf_flag, 0);

    // R5 13-bit wrap keeps lo[7:5]
    run = 0; mode = 2'b00;
    load(8'hFF, 8'hFE);
    run = 1; tick();
    chk(cnt_lo == 8'hFF && cnt_hi == 8'hFF, "R5", {cnt_hi, cnt_lo}, 16'hFFFF);
    tick();
    chk(cnt_lo == 8'hE0 && cnt_hi == 8'h00 && ovf_flag, "R5", {cnt_hi, cnt_lo}, 16'h00E0);

    // R6 reload from hi
    run = 0; mode = 2'b10;
    load(8'hA5, 8'hFE);
    run = 1; tick(); tick();
    chk(cnt_lo == 8'hA5 && cnt_hi == 8'hA5 && ovf_pulse, "R6", {cnt_hi, cnt_lo}, 16'hA5A5);

    // R9 overflow and clear together: flag stays
    load(8'hFF, 8'hFF);
    flag_clr = 1; tick(); quiet();
    chk(ovf_flag && cnt_lo == 8'hFF, "R9", ovf_flag, 1);

    // R7 stopped mode
    mode = 2'b11;
    load(8'h55, 8'h66);
    repeat (5) tick();
    chk({cnt_hi, cnt_lo} == 16'h5566 && !ovf_pulse, "R7", {cnt_hi, cnt_lo}, 16'h5566);

    // R3 gate low blocks counting
    mode = 2'b01; gate_en = 1; gate_pin = 0;
    repeat (4) tick();
    chk({cnt_hi, cnt_lo} == 16'h5566, "R3", {cnt_hi, cnt_lo}, 16'h5566);
    gate_pin = 1; tick(); gate_en = 0;
    chk({cnt_hi, cnt_lo} == 16'h5567, "R3", {cnt_hi, cnt_lo}, 16'h5567);

    // R8 external edge: 1 sample, 0 sample, count on next tick
    cnt_sel = 1; ext_pin = 0; tick(); tick();
    ext_pin = 1; tick();
    ext_pin = 0; tick();
    chk({cnt_hi, cnt_lo} == 16'h5567, "R8", {cnt_hi, cnt_lo}, 16'h5567);
    tick();
    chk({cnt_hi, cnt_lo} == 16'h5568, "R8", {cnt_hi, cnt_lo}, 16'h5568);
    tick();
    chk({cnt_hi, cnt_lo} == 16'h5568, "R8", {cnt_hi, cnt_lo}, 16'h5568);
    cnt_sel = 0;

    for (int i = 0; i < 6000; i++) begin
      cyc_en   = ($urandom % 4) != 0;
      run      = ($urandom % 10) != 0;
      gate_en  = ($urandom % 5) == 0;
      gate_pin = $urandom % 2;
      ext_pin  = $urandom % 2;
      wr_lo    = ($urandom % 50) == 0;
      wr_hi    = ($urandom % 50) == 0;
      wr_data  = ($urandom % 2) ? 8'hFF - 8'($urandom % 4) : 8'($urandom);
      flag_clr = ($urandom % 20) == 0;
      if (($urandom % 200) == 0) mode = 2'($urandom);
      if (($urandom % 300) == 0) cnt_sel = ~cnt_sel;
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule